// File: doc/BRIEF.md
# Bidirectional Debug Mailbox

This block is a two-way, single-word message channel between software running on a processor and an external debug host. Each direction has one data register and one occupancy flag. The processor side, called the target, writes words for the host and reads words the host has left for it. The debug host does the reverse through its own access port.

Both sides can read one read-only status word that carries the two flags. A data write sets the flag for its direction. The matching read on the other side clears it. This is the whole handshake: there is no FIFO and there are no acknowledge wires.

Both ports share one clock. Each access is a single-cycle strobe with a one-bit address: address 0 selects the status word and address 1 selects the data register for that side. Read data is combinational and reflects the register contents before the clock edge that ends the access. A write that finds its register still occupied is dropped, and a sticky overflow output on that side is raised.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both flags are 0, both data registers read as zero and both overflow outputs are 0.
- R2: At address 0, a read from either port returns the status word. Bit 1 is the outgoing flag (target-to-host word pending). Bit 0 is the incoming flag (host-to-target word pending). Bits 31:2 are zero.
- R3: A target write to address 1 while the outgoing flag is 0 stores the word and sets the outgoing flag on the next edge.
- R4: A host read of address 1 while the outgoing flag is 1 returns the stored word and clears the outgoing flag.
- R5: A host write to address 1 while the incoming flag is 0 stores the word and sets the incoming flag. A target read of address 1 while that flag is 1 returns the word and clears the flag.
- R6: A target write to address 1 while the outgoing flag is 1 changes neither the stored word nor the flag, and sets tgt_overflow, which then stays 1 until reset.
- R7: A host write to address 1 while the incoming flag is 1 changes neither the stored word nor the flag, and sets hst_overflow, which then stays 1 until reset.
- R8: A data read on either port while the flag for that register is 0 returns the last stored word and changes no flag.
- R9: When a host read and an accepted target write of the outgoing register fall in the same cycle, the new word is stored and the outgoing flag ends set. The same rule applies to the incoming register with the sides swapped. Any mix of simultaneous accesses on both ports is handled.
- R10: A write to address 0 from either port changes no flag and no data register.
- R11: While a port's valid input is 0, its write, address and data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tgt_valid | input | 1 | Target access strobe |
| tgt_write | input | 1 | Target access is a write (1) or a read (0) |
| tgt_addr | input | 1 | Target address: 0 status, 1 data |
| tgt_wdata | input | 32 | Target write data |
| tgt_rdata | output | 32 | Target read data for the addressed register |
| tgt_overflow | output | 1 | Sticky: a target write was dropped |
| hst_valid | input | 1 | Host access strobe |
| hst_write | input | 1 | Host access is a write (1) or a read (0) |
| hst_addr | input | 1 | Host address: 0 status, 1 data |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for the addressed register |
| hst_overflow | output | 1 | Sticky: a host write was dropped |

## Verification
The bench sweeps every starting flag pair against every combination of the five target and five host access kinds in one cycle, and compares the result with an arithmetic model. The main targets are the following.
- A write to a full register: a wrong design would overwrite the pending word, or would drop it without raising overflow.
- A read of an empty register: a wrong design would toggle or clear the flag.
- A read and an accepted write of the same register in one cycle: a wrong design that gives the clear priority would lose the new word's flag.
- Writes to the status address: a wrong design would let them alter the flags.
- Swapped flag bits in the status word: these show up at once in both status read-backs.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_DATA   = 1'b1;
  localparam int   BIT_IN_FULL  = 0;
  localparam int   BIT_OUT_FULL = 1;

  typedef struct packed {
    logic out_full;
    logic in_full;
  } mbx_flags_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              overflow
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              full_q, full_d;
  logic              ovf_q, ovf_d;
  logic              accept;
  logic              drain;
  logic              data_en;

  always_comb begin
    accept  = wr_req & ~full_q;
    drain   = rd_req & full_q;
    data_en = accept;
    data_d  = wdata;
    if (accept)     full_d = 1'b1;
    else if (drain) full_d = 1'b0;
    else            full_d = full_q;
    ovf_d = ovf_q | (wr_req & full_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
    end
  end

  assign data     = data_q;
  assign full     = full_q;
  assign overflow = ovf_q;

  a_r3_accept_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !full) |=> (full && data == $past(wdata)));
  a_r4_drain_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && full && !wr_req) |=> !full);
  a_r6_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !rd_req) |=> (full && $stable(data) && overflow));
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !full && !wr_req) |=> (!full && $stable(data)));
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              valid,
  input  logic              write,
  input  logic              addr,
  input  logic [DATA_W-1:0] data_word,
  input  mbx_flags_t        flags,
  output logic [DATA_W-1:0] rdata,
  output logic              data_wr,
  output logic              data_rd
);
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word               = '0;
    status_word[BIT_OUT_FULL] = flags.out_full;
    status_word[BIT_IN_FULL]  = flags.in_full;
    data_wr = valid &  write & (addr == ADDR_DATA);
    data_rd = valid & ~write & (addr == ADDR_DATA);
    rdata   = (addr == ADDR_DATA) ? data_word : status_word;
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_valid,
  input  logic              tgt_write,
  input  logic              tgt_addr,
  input  logic [DATA_W-1:0] tgt_wdata,
  output logic [DATA_W-1:0] tgt_rdata,
  output logic              tgt_overflow,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic              hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_overflow
);
  logic              srst_n;
  mbx_flags_t        flags;
  logic [DATA_W-1:0] out_word, in_word;
  logic              out_full, in_full;
  logic              t_wr, t_rd, h_wr, h_rd;

  mbx_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign flags.out_full = out_full;
  assign flags.in_full  = in_full;

  mbx_port #(.DATA_W(DATA_W)) u_tgt_port (
    .valid(tgt_valid), .write(tgt_write), .addr(tgt_addr),
    .data_word(in_word), .flags(flags), .rdata(tgt_rdata),
    .data_wr(t_wr), .data_rd(t_rd)
  );

  mbx_port #(.DATA_W(DATA_W)) u_hst_port (
    .valid(hst_valid), .write(hst_write), .addr(hst_addr),
    .data_word(out_word), .flags(flags), .rdata(hst_rdata),
    .data_wr(h_wr), .data_rd(h_rd)
  );

  mbx_slot #(.DATA_W(DATA_W)) u_out_slot (
    .clk(clk), .rst_n(srst_n), .wr_req(t_wr), .rd_req(h_rd),
    .wdata(tgt_wdata), .data(out_word), .full(out_full),
    .overflow(tgt_overflow)
  );

  mbx_slot #(.DATA_W(DATA_W)) u_in_slot (
    .clk(clk), .rst_n(srst_n), .wr_req(h_wr), .rd_req(t_rd),
    .wdata(hst_wdata), .data(in_word), .full(in_full),
    .overflow(hst_overflow)
  );

  a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!srst_n)
    (tgt_valid && tgt_write && tgt_addr == ADDR_STATUS &&
     hst_valid && hst_write && hst_addr == ADDR_STATUS)
    |=> ($stable(out_full) && $stable(in_full) && $stable(out_word) && $stable(in_word)));
  a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (hst_valid && !hst_write && hst_addr == ADDR_STATUS) |->
    (hst_rdata[DATA_W-1:2] == '0 && hst_rdata[1] == out_full));
  a_r11_idle_ports: assert property (@(posedge clk) disable iff (!srst_n)
    (!tgt_valid && !hst_valid) |=> ($stable(out_full) && $stable(in_full)));
endmodule

// File: tb/dbg_mailbox_bench.sv
module dbg_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tv, tw, ta, hv, hw, ha;
  logic [31:0] td, hd, trd, hrd;
  logic        tov, hov;
  int          total = 0, bad = 0;
  bit          done = 0;

  logic [31:0] m_out, m_in;
  logic        m_of, m_if, m_tov, m_hov;

  always #5 clk = ~clk;

  dbg_mailbox u_dbg_mailbox (
    .clk(clk), .rst_n(rst_n),
    .tgt_valid(tv), .tgt_write(tw), .tgt_addr(ta), .tgt_wdata(td),
    .tgt_rdata(trd), .tgt_overflow(tov),
    .hst_valid(hv), .hst_write(hw), .hst_addr(ha), .hst_wdata(hd),
    .hst_rdata(hrd), .hst_overflow(hov)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat();
    return {30'b0, m_of, m_if};
  endfunction

  task automatic do_reset();
    tv = 0; tw = 0; ta = 0; td = 0; hv = 0; hw = 0; ha = 0; hd = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_out = 0; m_in = 0; m_of = 0; m_if = 0; m_tov = 0; m_hov = 0;
  endtask

  // one cycle with both ports driven; read data checked against model
  task automatic step(string req, logic a_tv, logic a_tw, logic a_ta, logic [31:0] a_td,
                      logic a_hv, logic a_hw, logic a_ha, logic [31:0] a_hd);
    logic acc_o, acc_i;
    @(negedge clk);
    tv = a_tv; tw = a_tw; ta = a_ta; td = a_td;
    hv = a_hv; hw = a_hw; ha = a_ha; hd = a_hd;
    #2;
    if (a_tv && !a_tw) check(req, trd, a_ta ? m_in : stat());
    if (a_hv && !a_hw) check(req, hrd, a_ha ? m_out : stat());
    acc_o = a_tv & a_tw & a_ta & ~m_of;
    acc_i = a_hv & a_hw & a_ha & ~m_if;
    m_tov = m_tov | (a_tv & a_tw & a_ta & m_of);
    m_hov = m_hov | (a_hv & a_hw & a_ha & m_if);
    if (acc_o) begin m_out = a_td; m_of = 1; end
    else if (a_hv & ~a_hw & a_ha) m_of = 0;
    if (acc_i) begin m_in = a_hd; m_if = 1; end
    else if (a_tv & ~a_tw & a_ta) m_if = 0;
    @(posedge clk); #1;
    tv = 0; hv = 0;
  endtask

  task automatic status_both(string req, logic [31:0] exp);
    check(req, {30'b0, m_of, m_if}, exp);
    step(req, 1, 0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 tgt_ovf", {31'b0, tov}, 0);
    check("R1 hst_ovf", {31'b0, hov}, 0);
    status_both("R1 status", 0);
    step("R1 data zero", 1, 0, 1, 0, 1, 0, 1, 0);
    // R3 / R2 / R4
    step("R3 write", 1, 1, 1, 32'hA5A5_0001, 0, 0, 0, 0);
    status_both("R2 out flag bit1", 32'h2);
    step("R4 host read", 0, 0, 0, 0, 1, 0, 1, 0);
    status_both("R4 cleared", 0);
    // R5
    step("R5 host write", 0, 0, 0, 0, 1, 1, 1, 32'h5A5A_0002);
    status_both("R2 in flag bit0", 32'h1);
    step("R5 tgt read", 1, 0, 1, 0, 0, 0, 0, 0);
    status_both("R5 cleared", 0);
    // R6
    step("R6 first", 1, 1, 1, 32'h1111_1111, 0, 0, 0, 0);
    step("R6 second", 1, 1, 1, 32'h2222_2222, 0, 0, 0, 0);
    check("R6 tgt_ovf", {31'b0, tov}, 1);
    step("R6 kept word", 0, 0, 0, 0, 1, 0, 1, 0);
    check("R6 kept value", m_out, 32'h1111_1111);
    // R7
    step("R7 first", 0, 0, 0, 0, 1, 1, 1, 32'h3333_3333);
    step("R7 second", 0, 0, 0, 0, 1, 1, 1, 32'h4444_4444);
    check("R7 hst_ovf", {31'b0, hov}, 1);
    step("R7 kept word", 1, 0, 1, 0, 0, 0, 0, 0);
    check("R6 ovf sticky", {31'b0, tov}, 1);
    // R8
    step("R8 empty reads", 1, 0, 1, 0, 1, 0, 1, 0);
    status_both("R8 no flag change", 0);
    // R10
    step("R10 status writes", 1, 1, 0, 32'hFFFF_FFFF, 1, 1, 0, 32'hFFFF_FFFF);
    status_both("R10 flags", 0);
    step("R10 data kept", 1, 0, 1, 0, 1, 0, 1, 0);
    // R11
    @(negedge clk);
    tv = 0; tw = 1; ta = 1; td = 32'hDEAD_BEEF; hv = 0; hw = 1; ha = 1; hd = 32'hBEEF_DEAD;
    @(posedge clk); #1;
    status_both("R11 no valid", 0);
    // R9 same-cycle read and write
    step("R9 both", 1, 1, 1, 32'h9999_0009, 1, 0, 1, 0);
    status_both("R9 flag set", 32'h2);
    step("R9 word", 0, 0, 0, 0, 1, 0, 1, 0);
    // R9 sweep
    for (int pre = 0; pre < 4; pre++) begin
      for (int to = 0; to < 5; to++) begin
        for (int ho = 0; ho < 5; ho++) begin
          logic [31:0] wt, wh;
          wt = 32'hC000_0000 | (pre << 8) | (to << 4) | ho;
          wh = 32'h0D00_0000 | (pre << 8) | (to << 4) | ho;
          do_reset();
          if (pre[1]) step("R9 setup", 1, 1, 1, 32'h0123_4567, 0, 0, 0, 0);
          if (pre[0]) step("R9 setup", 0, 0, 0, 0, 1, 1, 1, 32'h7654_3210);
          step("R9 sweep op", to != 0, to >= 3, to == 2 || to == 4, wt,
               ho != 0, ho >= 3, ho == 2 || ho == 4, wh);
          check("R9 sweep tov", {31'b0, tov}, {31'b0, m_tov});
          check("R9 sweep hov", {31'b0, hov}, {31'b0, m_hov});
          step("R9 sweep status", 1, 0, 0, 0, 1, 0, 0, 0);
          step("R9 sweep data", 1, 0, 1, 0, 1, 0, 1, 0);
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule